// File: doc/BRIEF.md
# SPI Master Controller with Register Access

This block is a serial peripheral interface master. Software drives it through a small 32-bit register bus with an address, a write strobe, a read strobe and separate write and read data. It programs a clock divider and a control word, then writes words into an 8-entry transmit queue. The block shifts each word out on MOSI while it samples MISO, and it stores each received word in an 8-entry receive queue. Software reads those words back from the receive data register. The control word selects the word length, the bit order, the clock polarity and phase, internal loopback, master role, enable and a soft reset.

A single level interrupt tells software that the transmit queue is empty and the shifter is idle. Software then empties the receive queue and refills the transmit queue with up to 8 words. Chip select is not part of this block. The register bus is a plain register interface with no valid/ready handshake. A write to a full transmit queue, or a word received while the receive queue is full, is dropped rather than stalled. No back-pressure ever reaches the bus or the serial side.

Register byte offsets: 0x00 divider, 0x04 transmit data (write), 0x08 receive data (read), 0x0C control, 0x10 interrupt enable. Any other offset reads 0.

Top module: `spim_core`

## Requirements
- R1: After reset, `irq`, `sclk`, `sclk_oe` and `mosi_oe` are 0. The divider, control and interrupt-enable registers read 0, and the receive data register reads 0.
- R2: The divider register holds a 16-bit value N in bits [15:0], where 0 means 65536. Each SCLK half period lasts N clock cycles. The first SCLK edge of a transfer comes N+1 cycles after the cycle in which the transmit word is written.
- R3: Control bits [3:0] hold the word length minus one: 0x7 gives 8-bit words and 0xF gives 16-bit words. A word takes twice that many SCLK edges. A 16-bit word sent MSB first puts its upper byte on the line first.
- R4: Control bit 4 set sends and receives MSB first. Clear, it sends and receives LSB first.
- R5: Control bit 6 sets the SCLK idle level, and SCLK rests there while no word is in progress. With control bit 5 clear, data is sampled on the leading SCLK edge and changed on the trailing edge. With bit 5 set, data is changed on the leading edge and sampled on the trailing edge.
- R6: With control bit 10 set, the receive path takes the MOSI bit internally, and the MISO pin has no effect on received data.
- R7: The transmit queue holds 8 words, and a write to it when full is dropped. While words remain queued, they follow one another with no idle time: every SCLK edge in a burst is exactly N cycles after the previous one.
- R8: A read of the receive data register pops one word from the 8-entry receive queue. A read when the queue is empty returns the last word popped. A word that completes while the receive queue is full is dropped.
- R9: `irq` equals interrupt-enable bit 2 ANDed with "transmit queue empty and no word in progress".
- R10: While control bit 7 is set, both queues are flushed, any word in progress is abandoned and SCLK returns to its idle level. The other control fields keep their values.
- R11: Transfers start only when control bit 9 (enable) and bit 8 (master) are both set. `sclk_oe` and `mosi_oe` follow bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the receive queue at offset 0x08 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` in the same cycle |
| sclk | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data output enable |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Transmit-drained interrupt, level |

## Verification
Two events can land in the same cycle: a word finishes on its final SCLK edge and the next queued word is loaded on that same edge, while a bus write refills the transmit queue. The bench queues several words so that completion, reload and refill overlap. It then judges the result by counting SCLK edges and timing the span from the first edge to the last, which must equal the edge count minus one, times N. The interrupt is compared on every clock against a model of words still pending. An early or late assertion at the word boundary therefore shows up as a mismatch.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [4:0] A_DIV = 5'h00;
  localparam logic [4:0] A_TXD = 5'h04;
  localparam logic [4:0] A_RXD = 5'h08;
  localparam logic [4:0] A_CTL = 5'h0C;
  localparam logic [4:0] A_IEN = 5'h10;

  localparam int CTL_W  = 13;
  localparam int C_MSB  = 4;
  localparam int C_CPHA = 5;
  localparam int C_CPOL = 6;
  localparam int C_SRST = 7;
  localparam int C_MST  = 8;
  localparam int C_EN   = 9;
  localparam int C_LOOP = 10;
  localparam int IEN_TXE = 2;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> full); // R7
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> empty); // R8
endmodule

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // a divider of 0 wraps to all ones, giving the full 2**DIV_W count
  assign lim  = div - 1'b1;
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  AST_TICK_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (cnt == '0)); // R2
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       go,
  input  logic                       tx_avail,
  input  logic [DATA_W-1:0]          tx_word,
  input  logic [$clog2(DATA_W)-1:0]  wlen_m1,
  input  logic                       msb_first,
  input  logic                       cpha,
  input  logic                       cpol,
  input  logic                       loop,
  input  logic                       miso,
  input  logic                       tick,
  output logic                       tx_pop,
  output logic                       rx_push,
  output logic [DATA_W-1:0]          rx_word,
  output logic                       busy,
  output logic                       sclk,
  output logic                       mosi
);
  localparam int WL_W = $clog2(DATA_W);
  localparam int EW   = WL_W + 1;

  logic [EW-1:0]     edge_q;
  logic              ph, out_bit;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_nxt;
  logic              leading, last, load, upd, smp, in_bit;
  logic [EW-1:0]     last_idx;

  function automatic logic pick(input logic [DATA_W-1:0] w, input logic m,
                                input logic [WL_W-1:0] l);
    return m ? w[l] : w[0];
  endfunction

  function automatic logic [DATA_W-1:0] adv(input logic [DATA_W-1:0] w, input logic m);
    return m ? (w << 1) : (w >> 1);
  endfunction

  assign leading  = !edge_q[0];
  assign last_idx = {wlen_m1, 1'b1};
  assign last     = busy && tick && (edge_q == last_idx);
  assign load     = (!busy || last) && go && tx_avail && !clr;
  assign upd      = busy && tick && (cpha ? leading : (!leading && !last));
  assign smp      = busy && tick && (cpha ? !leading : leading);
  assign in_bit   = loop ? out_bit : miso;

  always_comb begin
    rx_nxt = rx_sh;
    if (smp) rx_nxt = msb_first ? {rx_sh[DATA_W-2:0], in_bit} : {in_bit, rx_sh[DATA_W-1:1]};
  end

  assign rx_word = msb_first ? (rx_nxt & ({DATA_W{1'b1}} >> (DATA_W - 1 - int'(wlen_m1))))
                             : (rx_nxt >> (DATA_W - 1 - int'(wlen_m1)));
  assign rx_push = last;
  assign tx_pop  = load;
  assign sclk    = cpol ^ ph;
  assign mosi    = out_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; edge_q <= '0; ph <= 1'b0; out_bit <= 1'b0;
      tx_sh <= '0; rx_sh <= '0;
    end else if (clr) begin
      busy <= 1'b0; edge_q <= '0; ph <= 1'b0;
    end else begin
      rx_sh <= rx_nxt;
      if (busy && tick) begin
        ph     <= ~ph;
        edge_q <= edge_q + 1'b1;
      end
      if (upd) begin
        out_bit <= pick(tx_sh, msb_first, wlen_m1);
        tx_sh   <= adv(tx_sh, msb_first);
      end
      if (last) begin
        busy <= 1'b0; edge_q <= '0; ph <= 1'b0;
      end
      if (load) begin
        busy   <= 1'b1;
        edge_q <= '0;
        ph     <= 1'b0;
        tx_sh  <= cpha ? tx_word : adv(tx_word, msb_first);
        if (!cpha) out_bit <= pick(tx_word, msb_first, wlen_m1);
      end
    end
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (sclk == cpol)); // R5
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (last && go && tx_avail && !clr) |=> busy); // R7
  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !busy); // R10
endmodule

// File: rtl/spim_core.sv
module spim_core #(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        sclk_oe,
  output logic        mosi,
  output logic        mosi_oe,
  input  logic        miso,
  output logic        irq
);
  import spim_pkg::*;
  localparam int WL_W = $clog2(DATA_W);

  logic [DIV_W-1:0]  div_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              ien_q;
  logic [DATA_W-1:0] last_rx;

  logic              tx_empty, tx_full, tx_pop, wr_tx;
  logic [DATA_W-1:0] tx_head;
  logic              rx_empty, rx_full, rx_push, rd_rx;
  logic [DATA_W-1:0] rx_head, rx_word;
  logic              tick, busy, clr, go;

  assign clr   = ctl_q[C_SRST];
  assign go    = ctl_q[C_EN] && ctl_q[C_MST];
  assign wr_tx = reg_wr && (reg_addr == A_TXD);
  assign rd_rx = reg_rd && (reg_addr == A_RXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; ctl_q <= '0; ien_q <= 1'b0; last_rx <= '0;
    end else begin
      if (reg_wr && reg_addr == A_DIV) div_q <= reg_wdata[DIV_W-1:0];
      if (reg_wr && reg_addr == A_CTL) ctl_q <= reg_wdata[CTL_W-1:0];
      if (reg_wr && reg_addr == A_IEN) ien_q <= reg_wdata[IEN_TXE];
      if (rd_rx && !rx_empty)          last_rx <= rx_head;
    end
  end

  always_comb begin
    case (reg_addr)
      A_DIV:   reg_rdata = 32'(div_q);
      A_CTL:   reg_rdata = 32'(ctl_q);
      A_IEN:   reg_rdata = 32'(ien_q) << IEN_TXE;
      A_RXD:   reg_rdata = 32'(rx_empty ? last_rx : rx_head);
      default: reg_rdata = '0;
    endcase
  end

  spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst_n, .flush(clr), .push(wr_tx), .din(reg_wdata[DATA_W-1:0]),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full));

  spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst_n, .flush(clr), .push(rx_push), .din(rx_word),
    .pop(rd_rx), .dout(rx_head), .empty(rx_empty), .full(rx_full));

  spim_baud #(.DIV_W(DIV_W)) u_baud (
    .clk, .rst_n, .run(busy), .div(div_q), .tick);

  spim_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk, .rst_n, .clr, .go, .tx_avail(!tx_empty), .tx_word(tx_head),
    .wlen_m1(ctl_q[WL_W-1:0]), .msb_first(ctl_q[C_MSB]), .cpha(ctl_q[C_CPHA]),
    .cpol(ctl_q[C_CPOL]), .loop(ctl_q[C_LOOP]), .miso, .tick,
    .tx_pop, .rx_push, .rx_word, .busy, .sclk, .mosi);

  assign sclk_oe = ctl_q[C_MST];
  assign mosi_oe = ctl_q[C_MST];
  assign irq     = ien_q && tx_empty && !busy;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq); // R9
  AST_NO_START_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ctl_q[C_MST]) |=> !busy); // R11
  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && tx_full && !tx_pop && !clr) |=> tx_full); // R7
  AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && rx_empty) |=> $stable(last_rx)); // R8
endmodule

// File: tb/test_spim_core.sv
module test_spim_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk, sclk_oe, mosi, mosi_oe, irq;
  logic        miso = 1'b0;

  spim_core i_spim_core (.clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata,
    .reg_rdata, .sclk, .sclk_oe, .mosi, .mosi_oe, .miso, .irq);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  bit cpol_m, cpha_m, msb_m, mst_m, ien_m;
  int wl_m = 8;
  int pending = 0;
  bit chk_on = 1'b0, hold = 1'b0;
  // serial monitor / slave model
  logic sclk_prev = 1'b0;
  int   edges = 0, first_e = 0, last_e = 0;
  int   mbits = 0, slv_idx = 0;
  logic [15:0] macc = '0, slv_word = '0;
  logic [15:0] mosi_q[$];
  logic [15:0] slv_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_on && !hold) begin
      if (sclk !== sclk_prev) begin
        bit lead;
        lead = (sclk_prev == cpol_m);
        edges++;
        if (edges == 1) first_e = cyc;
        last_e = cyc;
        if (lead != cpha_m) begin
          if (msb_m) macc = {macc[14:0], mosi};
          else       macc[mbits] = mosi;
          mbits++;
          if (mbits == wl_m) begin mosi_q.push_back(macc); mbits = 0; macc = '0; end
        end
        if (!lead) begin
          slv_idx++;
          if (slv_idx == wl_m) begin
            slv_idx = 0;
            pending--;
            slv_word = (slv_q.size() > 0) ? slv_q.pop_front() : 16'h0;
          end
        end
      end
      sclk_prev = sclk;
      chk("R11 oe follows master", {30'd0, sclk_oe, mosi_oe}, {30'd0, mst_m, mst_m});
      chk("R9 irq", irq, ien_m && (pending == 0));
      if (pending == 0) chk("R5 idle level", sclk, cpol_m);
    end
    miso = msb_m ? slv_word[wl_m-1-slv_idx] : slv_word[slv_idx];
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    if (a == 5'h0C && d[7]) hold = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    if (a == 5'h10) ien_m = d[2];
    if (a == 5'h0C) begin
      cpol_m = d[6]; cpha_m = d[5]; msb_m = d[4]; mst_m = d[8];
      wl_m = int'(d[3:0]) + 1;
      if (d[7]) begin
        @(posedge clk); #1;
        pending = 0; mbits = 0; macc = '0; slv_idx = 0;
        hold = 1'b0;
      end
      sclk_prev = d[6];
    end
  endtask

  task automatic push_tx(logic [15:0] d);
    wr(5'h04, {16'd0, d});
    pending++;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic slave_start();
    slv_word = slv_q.pop_front();
    slv_idx = 0;
  endtask

  task automatic wait_done(int limit);
    int n = 0;
    while (pending != 0 && n < limit) begin @(posedge clk); n++; end
    if (pending != 0) chk("R7 transfer completes", pending, 0);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all) actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int t0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq", irq, 0);
    chk("R1 sclk", sclk, 0);
    chk("R1 oe", {sclk_oe, mosi_oe}, 0);
    rst_n = 1'b1;
    @(posedge clk);
    rd(5'h00, v); chk("R1 div", v, 0);
    rd(5'h0C, v); chk("R1 ctl", v, 0);
    rd(5'h10, v); chk("R1 ien", v, 0);
    rd(5'h08, v); chk("R1 rx", v, 0);
    chk_on = 1'b1;

    // mode 0, MSB first, 8 bit, two words back to back
    wr(5'h00, 7);
    wr(5'h10, 4);
    wr(5'h0C, 32'h317);
    chk("R9 irq when drained", irq, 1);
    slv_q.push_back(16'hA5); slv_q.push_back(16'h3C); slave_start();
    edges = 0;
    push_tx(16'h5A); push_tx(16'hC3);
    chk("R9 irq low while pending", irq, 0);
    wait_done(2000);
    chk("R3 edge count", edges, 32);
    chk("R2 edge span", last_e - first_e, 31 * 7);
    chk("R4 mosi word 0", mosi_q.pop_front(), 16'h5A);
    chk("R4 mosi word 1", mosi_q.pop_front(), 16'hC3);
    rd(5'h08, v); chk("R5 rx word 0", v, 32'hA5);
    rd(5'h08, v); chk("R5 rx word 1", v, 32'h3C);

    // mode 3, LSB first
    wr(5'h0C, 32'h367);
    chk("R5 idle high", sclk, 1);
    slv_q.push_back(16'h17); slave_start();
    push_tx(16'h81);
    wait_done(2000);
    chk("R4 lsb mosi", mosi_q.pop_front(), 16'h81);
    rd(5'h08, v); chk("R4 lsb rx", v, 32'h17);

    // mode 1, 16-bit, MSB first: upper byte first
    wr(5'h0C, 32'h33F);
    slv_q.push_back(16'h1234); slave_start();
    edges = 0;
    push_tx(16'hBEEF);
    wait_done(4000);
    chk("R3 16-bit edges", edges, 32);
    chk("R3 16-bit mosi", mosi_q.pop_front(), 16'hBEEF);
    rd(5'h08, v); chk("R3 16-bit rx", v, 32'h1234);

    // loopback ignores MISO
    wr(5'h0C, 32'h717);
    slv_q.push_back(16'hFF); slave_start();
    push_tx(16'h96);
    wait_done(2000);
    void'(mosi_q.pop_front());
    rd(5'h08, v); chk("R6 loopback rx", v, 32'h96);

    // transmit queue depth and enable gate
    chk_on = 1'b0;
    wr(5'h0C, 32'h117);
    for (int i = 0; i < 9; i++) wr(5'h04, 32'h10 + i);
    pending = 8;
    edges = 0;
    chk_on = 1'b1;
    repeat (200) @(posedge clk);
    chk("R11 no start without enable", edges, 0);
    for (int i = 0; i < 8; i++) slv_q.push_back(16'h20 + 16'(i));
    slave_start();
    wr(5'h0C, 32'h317);
    wait_done(3000);
    chk("R7 words sent", mosi_q.size(), 8);
    for (int i = 0; i < 8; i++) chk("R7 queued word", mosi_q.pop_front(), 16'h10 + 16'(i));
    chk("R7 burst edges", edges, 128);
    chk("R7 no gap", last_e - first_e, 127 * 7);
    for (int i = 0; i < 8; i++) begin rd(5'h08, v); chk("R8 pop order", v, 32'h20 + i); end
    rd(5'h08, v); chk("R8 empty read repeats", v, 32'h27);

    // receive overflow
    for (int i = 0; i < 9; i++) slv_q.push_back(16'h40 + 16'(i));
    slave_start();
    for (int i = 0; i < 8; i++) push_tx(16'h30 + 16'(i));
    wait_done(3000);
    push_tx(16'h38);
    wait_done(2000);
    mosi_q.delete();
    for (int i = 0; i < 8; i++) begin rd(5'h08, v); chk("R8 overflow keep", v, 32'h40 + i); end
    rd(5'h08, v); chk("R8 overflow dropped", v, 32'h47);

    // slave role, then soft reset
    wr(5'h0C, 32'h217);
    chk("R11 slave oe", {sclk_oe, mosi_oe}, 0);
    edges = 0;
    push_tx(16'h11);
    repeat (300) @(posedge clk);
    chk("R11 slave no edges", edges, 0);
    chk("R9 irq low with queued word", irq, 0);
    wr(5'h0C, 32'h297);
    #1 chk("R10 flushed irq", irq, 1);
    rd(5'h0C, v); chk("R10 fields kept", v, 32'h297);
    wr(5'h0C, 32'h317);
    repeat (200) @(posedge clk);
    chk("R10 queue flushed", edges, 0);

    // divider 0 means 65536, abort with soft reset
    wr(5'h00, 0);
    rd(5'h00, v); chk("R2 div readback", v, 0);
    slv_q.push_back(16'h00); slave_start();
    edges = 0;
    push_tx(16'h77);
    t0 = cyc;
    begin
      int n = 0;
      while (edges == 0 && n < 70000) begin @(posedge clk); n++; end
    end
    chk("R2 div0 first edge", first_e - t0, 65537);
    wr(5'h0C, 32'h397);
    #1 chk("R10 sclk idle after abort", sclk, 0);
    chk("R10 irq after abort", irq, 1);
    wr(5'h0C, 32'h317);
    repeat (5) @(posedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule